// File: doc/BRIEF.md
# Partial-Response Transmit Encoder

This block sits on the transmit side of a serial link, just before the last serialization stage. On each accepted clock it takes a parallel word of NRZ bits. For every bit slot it produces the four control bits of a segmented output driver, whose weighted paths are summed in the analog stage. The block supports three modes: plain NRZ, NRZ with a single-tap de-emphasis, and duo-binary. In duo-binary mode a differential precoder runs through the word, bit by bit, so that the summed driver output forms a three-level symbol.

Two pieces of history are carried from one word to the next: the last data bit and the last precoder bit. De-emphasis and precoding therefore stay continuous across word boundaries. Each slot also has a two-bit reference symbol value, which downstream checking logic can compare against the analog eye. The mode is sampled together with each word, so a mode change takes effect on a word boundary.

Top module: `txenc_top`

## Requirements
- R1: An asynchronous active-low reset clears out_vld, path_q, sym_q, the stored previous data bit and the stored previous precoder bit to 0.
- R2: When word_vld is high at a rising edge, the encoded word appears on path_q and sym_q one cycle later with out_vld high. When word_vld is low, out_vld is low in the following cycle.
- R3: While word_vld is low, path_q, sym_q and both history bits keep their values, whatever word_in and mode_sel carry.
- R4: With mode_sel = 0 (NRZ), all four path bits of a slot equal that slot's data bit x(k), and the slot symbol equals 2·x(k).
- R5: With mode_sel = 1 (de-emphasis), b0, b1 and b2 equal x(k) and b3 equals NOT x(k-1). For slot 0, x(k-1) is the last bit of the previously accepted word. The slot symbol equals 2·x(k).
- R6: With mode_sel = 2 (duo-binary), p(k) = p(k-1) XOR x(k). b0 and b1 equal p(k), and b2 and b3 equal p(k-1). For slot 0, p(k-1) is the last precoder bit of the previously accepted word.
- R7: In duo-binary mode the slot symbol equals p(k) + p(k-1), which takes the values 0, 1 or 2. The value 3 never appears on any slot.
- R8: mode_sel = 3 encodes exactly like NRZ.
- R9: Both history bits update on every accepted word, whatever the mode. A switch between modes therefore continues from the true previous data and precoder bits.
- R10: Slot i of word_in is bit i, and bit 0 is the earliest in time. Slot i drives path_q[4i+3:4i] as {b3,b2,b1,b0} and sym_q[2i+1:2i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_vld | input | 1 | Accept word_in and mode_sel this cycle |
| mode_sel | input | 2 | 0 NRZ, 1 de-emphasis, 2 duo-binary, 3 NRZ |
| word_in | input | LANES | NRZ data word, bit 0 earliest |
| out_vld | output | 1 | path_q and sym_q hold a newly encoded word |
| path_q | output | 4*LANES | Driver path bits, 4 per slot, b0 in the lowest bit |
| sym_q | output | 2*LANES | Reference symbol level, 2 bits per slot |

## Verification
The bench builds the block with its default LANES = 4, which is the width of the final serialization stage. At this width a word boundary follows every fourth bit, so the carried data bit and the carried precoder bit are tested on nearly every word. The bench drives words with long runs and alternating runs in every mode. It switches modes between words, holds word_vld low while the inputs toggle, and applies a reset in the middle of a run. Each output is compared with a bit-serial model that steps one bit at a time.

// File: rtl/txenc_pkg.sv
package txenc_pkg;

  typedef enum logic [1:0] {
    ENC_NRZ    = 2'd0,
    ENC_DEEMPH = 2'd1,
    ENC_DUOB   = 2'd2,
    ENC_RSVD   = 2'd3
  } enc_mode_e;

  typedef struct packed {
    logic b3;
    logic b2;
    logic b1;
    logic b0;
  } path_t;

endpackage

// File: rtl/txenc_precode.sv
module txenc_precode #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] x_word,
  input  logic             p_carry,
  output logic [LANES-1:0] p_word
);

  // serial XOR chain, slot 0 earliest
  for (genvar i = 0; i < LANES; i++) begin : g_chain
    if (i == 0) begin : g_head
      assign p_word[i] = p_carry ^ x_word[i];
    end else begin : g_link
      assign p_word[i] = p_word[i-1] ^ x_word[i];
    end
  end

endmodule

// File: rtl/txenc_slot_map.sv
module txenc_slot_map
  import txenc_pkg::*;
(
  input  enc_mode_e   mode,
  input  logic        x_cur,
  input  logic        x_prev,
  input  logic        p_cur,
  input  logic        p_prev,
  output path_t       path,
  output logic [1:0]  sym
);

  always_comb begin
    case (mode)
      ENC_DEEMPH: begin
        path = {~x_prev, x_cur, x_cur, x_cur};
        sym  = {x_cur, 1'b0};
      end
      ENC_DUOB: begin
        path = {p_prev, p_prev, p_cur, p_cur};
        sym  = {1'b0, p_cur} + {1'b0, p_prev};
      end
      default: begin
        path = {4{x_cur}};
        sym  = {x_cur, 1'b0};
      end
    endcase
  end

endmodule

// File: rtl/txenc_hist.sv
module txenc_hist (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic x_last,
  input  logic p_last,
  output logic prev_x,
  output logic prev_p
);

  logic prev_x_d;
  logic prev_p_d;

  always_comb begin
    prev_x_d = prev_x;
    prev_p_d = prev_p;
    if (en) begin
      prev_x_d = x_last;
      prev_p_d = p_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_x <= 1'b0;
      prev_p <= 1'b0;
    end else begin
      prev_x <= prev_x_d;
      prev_p <= prev_p_d;
    end
  end

endmodule

// File: rtl/txenc_top.sv
module txenc_top
  import txenc_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 word_vld,
  input  logic [1:0]           mode_sel,
  input  logic [LANES-1:0]     word_in,
  output logic                 out_vld,
  output logic [4*LANES-1:0]   path_q,
  output logic [2*LANES-1:0]   sym_q
);

  localparam int PW = 4 * LANES;
  localparam int SW = 2 * LANES;

  enc_mode_e        mode_e;
  logic             hist_x;
  logic             hist_p;
  logic [LANES-1:0] p_chain;
  logic [PW-1:0]    path_c;
  logic [PW-1:0]    path_d;
  logic [SW-1:0]    sym_c;
  logic [SW-1:0]    sym_d;
  logic             vld_d;

  assign mode_e = enc_mode_e'(mode_sel);

  txenc_precode #(.LANES(LANES)) u_pre (
    .x_word  (word_in),
    .p_carry (hist_p),
    .p_word  (p_chain)
  );

  txenc_hist u_hist (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (word_vld),
    .x_last (word_in[LANES-1]),
    .p_last (p_chain[LANES-1]),
    .prev_x (hist_x),
    .prev_p (hist_p)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_slot
    logic  xp;
    logic  pp;
    path_t pth;
    if (i == 0) begin : g_first
      assign xp = hist_x;
      assign pp = hist_p;
    end else begin : g_next
      assign xp = word_in[i-1];
      assign pp = p_chain[i-1];
    end
    txenc_slot_map u_map (
      .mode   (mode_e),
      .x_cur  (word_in[i]),
      .x_prev (xp),
      .p_cur  (p_chain[i]),
      .p_prev (pp),
      .path   (pth),
      .sym    (sym_c[2*i+:2])
    );
    assign path_c[4*i+:4] = pth;
  end

  always_comb begin
    vld_d  = word_vld;
    path_d = path_q;
    sym_d  = sym_q;
    if (word_vld) begin
      path_d = path_c;
      sym_d  = sym_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      path_q  <= '0;
      sym_q   <= '0;
    end else begin
      out_vld <= vld_d;
      path_q  <= path_d;
      sym_q   <= sym_d;
    end
  end

  // ---------------- checks on the registered word ----------------
  logic [LANES-1:0] pair_ok;
  logic [LANES-1:0] flat_ok;
  logic [LANES-1:0] lvl_ok;

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    assign pair_ok[i] = (path_q[4*i] == path_q[4*i+1]) && (path_q[4*i+2] == path_q[4*i+3]);
    assign flat_ok[i] = (path_q[4*i+:4] == 4'h0) || (path_q[4*i+:4] == 4'hF);
    assign lvl_ok[i]  = (sym_q[2*i+:2] != 2'b11);
  end

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> out_vld);

  // R2
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |=> !out_vld);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |=> ($stable(path_q) && $stable(sym_q)));

  // R6
  duob_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && mode_sel == 2'd2) |=> (&pair_ok));

  // R4 R8
  nrz_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && (mode_sel == 2'd0 || mode_sel == 2'd3)) |=> (&flat_ok));

  // R7
  level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (&lvl_ok));

endmodule

// File: tb/sim_txenc_top.sv
module sim_txenc_top;

  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 4;

  logic             clk;
  logic             rst_n;
  logic             word_vld;
  logic [1:0]       mode_sel;
  logic [LANES-1:0] word_in;
  logic             out_vld;
  logic [4*LANES-1:0] path_q;
  logic [2*LANES-1:0] sym_q;

  int n_chk;
  int n_err;
  logic mx;
  logic mp;

  txenc_top #(.LANES(LANES)) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_vld (word_vld),
    .mode_sel (mode_sel),
    .word_in  (word_in),
    .out_vld  (out_vld),
    .path_q   (path_q),
    .sym_q    (sym_q)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    word_vld = 1'b0;
    mode_sel = 2'd0;
    word_in  = '0;
    mx = 1'b0;
    mp = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive one word at a negedge, check at the following negedge
  task automatic send(input logic [LANES-1:0] x, input logic [1:0] m, input string req);
    logic [4*LANES-1:0] ep;
    logic [2*LANES-1:0] es;
    word_vld = 1'b1;
    mode_sel = m;
    word_in  = x;
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < LANES; i++) begin
      logic xi;
      logic pk;
      xi = x[i];
      pk = mp ^ xi;
      case (m)
        2'd1: begin ep[4*i+:4] = {~mx, xi, xi, xi}; es[2*i+:2] = {xi, 1'b0}; end
        2'd2: begin ep[4*i+:4] = {mp, mp, pk, pk};  es[2*i+:2] = {1'b0, pk} + {1'b0, mp}; end
        default: begin ep[4*i+:4] = {4{xi}};        es[2*i+:2] = {xi, 1'b0}; end
      endcase
      mx = xi;
      mp = pk;
    end
    check({req, " out_vld"}, 32'(out_vld), 32'd1);
    check({req, " path"}, 32'(path_q), 32'(ep));
    check({req, " sym"}, 32'(sym_q), 32'(es));
    word_vld = 1'b0;
  endtask

  task automatic t_reset();
    rst_n    = 1'b0;
    word_vld = 1'b0;
    mode_sel = 2'd0;
    word_in  = '0;
    mx = 1'b0;
    mp = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 out_vld in reset", 32'(out_vld), 32'd0);
    check("R1 path in reset", 32'(path_q), 32'd0);
    check("R1 sym in reset", 32'(sym_q), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 idle out_vld", 32'(out_vld), 32'd0);
    // R1: cleared history -> all-zero duo-binary word
    send(4'b0000, 2'd2, "R1 history cleared");
    check("R1 literal", 32'(path_q), 32'h0000);
  endtask

  task automatic t_nrz();
    send(4'b0001, 2'd0, "R10 packing");
    check("R10 literal path", 32'(path_q), 32'h000F);
    check("R10 literal sym", 32'(sym_q), 32'h02);
    send(4'b1010, 2'd0, "R4 nrz alt");
    send(4'b0110, 2'd0, "R4 nrz mid");
    send(4'b1111, 2'd0, "R4 nrz ones");
  endtask

  task automatic t_deemph();
    send(4'b0011, 2'd1, "R5 deemph carry one");
    send(4'b1100, 2'd1, "R5 deemph carry zero");
    send(4'b1111, 2'd1, "R5 deemph run");
    send(4'b0000, 2'd1, "R5 deemph fall");
    send(4'b0101, 2'd1, "R5 deemph alt");
  endtask

  task automatic t_duob();
    send(4'b1111, 2'd2, "R6 duob ones");
    send(4'b0000, 2'd2, "R6 duob zeros");
    send(4'b1001, 2'd2, "R6 duob mix");
    send(4'b0110, 2'd2, "R7 duob levels");
    // R7: hold p at 1 so a level-2 symbol appears
    if (mp == 1'b0) send(4'b1000, 2'd2, "R7 set p");
    send(4'b0000, 2'd2, "R7 level two");
    check("R7 literal level two", 32'(sym_q), 32'hAA);
  endtask

  task automatic t_code3();
    send(4'b1011, 2'd3, "R8 code3");
    send(4'b0100, 2'd3, "R8 code3 b");
  endtask

  task automatic t_switch();
    send(4'b0111, 2'd0, "R9 nrz before duob");
    send(4'b0101, 2'd2, "R9 duob after nrz");
    send(4'b1110, 2'd1, "R9 deemph after duob");
    send(4'b0011, 2'd2, "R9 duob after deemph");
  endtask

  task automatic t_hold();
    logic [4*LANES-1:0] sp;
    logic [2*LANES-1:0] ss;
    send(4'b1101, 2'd2, "R3 preload");
    sp = path_q;
    ss = sym_q;
    word_vld = 1'b0;
    for (int k = 0; k < 5; k++) begin
      mode_sel = 2'(k);
      word_in  = 4'(k * 5 + 3);
      @(negedge clk);
    end
    check("R2 out_vld low", 32'(out_vld), 32'd0);
    check("R3 path held", 32'(path_q), 32'(sp));
    check("R3 sym held", 32'(sym_q), 32'(ss));
    send(4'b0100, 2'd2, "R3 history held duob");
    send(4'b1010, 2'd1, "R3 history held deemph");
  endtask

  task automatic t_midreset();
    send(4'b1111, 2'd1, "R1 pre reset");
    do_reset();
    check("R1 out_vld after reset", 32'(out_vld), 32'd0);
    check("R1 path after reset", 32'(path_q), 32'd0);
    send(4'b0000, 2'd1, "R1 x history cleared");
    send(4'b0000, 2'd2, "R1 p history cleared");
  endtask

  initial begin
    n_chk = 0;
    n_err = 0;
    t_reset();
    t_nrz();
    t_deemph();
    t_duob();
    t_code3();
    t_switch();
    t_hold();
    t_midreset();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule